// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block puts a one-time-programmable fuse array behind a small 32-bit register port. The array is held on chip as a set of 32-bit fuse words. Software first selects a word with an address register and a bit with a bit-select register. It then reads the word through a gated data-out register, or programs a single bit by writing a program-enable register. Data-out returns real fuse contents only when three separate enable registers all have bit 0 set. In every other case it returns 0xFF.

Programming works one bit at a time. A map of written bits, with one flag per fuse bit, records every bit that has already been programmed. A second attempt on the same bit is dropped and raises a sticky error flag. At reset every fuse word reads as all ones and the written-bit map is cleared. A configurable serial number is placed at a fixed word index, and its bitwise complement is placed at the next index. The remaining control registers are plain read/write storage. All register writes and program operations complete in one clock cycle. Read data is registered and returns one cycle after the request.

Top module: `otp_fuse_ctrl`

Register index is `addr_i[7:2]`; `addr_i[1:0]` is ignored. Indices: 0 word address, 1 bit select, 2 data in, 3 data out, 4 chip enable, 5 strobe enable, 6 trim enable, 7 program enable, 8 redundancy select, 9 clock control, 10 test mode, 11 test repair, 12 test control, 13 program control, 14 status. Indices 15 and above are unmapped.

## Requirements
- R1: A read request (`req_i`=1, `we_i`=0) returns its 32-bit data on `rdata_o` with `rvalid_o`=1 in the next cycle only. Indices 1, 2, 4, 5, 6, 8, 9, 10, 11, 12 and 13 read back the last full 32-bit value written, and 0 after reset.
- R2: Data out (index 3) is read-only. A write to it changes no state.
- R3: A read of data out returns the fuse word at the current address only when bit 0 of chip enable, strobe enable and trim enable are all 1. Otherwise it returns 32'h0000_00FF.
- R4: The word address register keeps only the low ADDR_W bits of the written value and reads back zero-extended. The default is 10 bits, for 1024 words.
- R5: Program enable stores only bit 0 of the written value. A program operation starts only on a write to it with bit 0 = 1 while the redundancy select register is 0. Otherwise the fuses and the map are unchanged.
- R6: A program operation sets bit `bitsel[4:0]` of the addressed word to data-in bit 0 and marks that bit as written.
- R7: A program operation on a bit already marked as written leaves the fuse word unchanged and sets the error flag.
- R8: The error flag drives `err_o` and status bit 0. It stays set until a status write with bit 0 = 1. When a new error arrives in the same cycle as a clear, the error wins.
- R9: After reset every fuse word is 32'hFFFF_FFFF and no bit is marked written. Word SERIAL_IDX holds SERIAL and word SERIAL_IDX+1 holds ~SERIAL. `rvalid_o` and `err_o` are 0.
- R10: A read of an unmapped index returns 0, and a write to an unmapped index changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address; register index in bits 7:2 |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| err_o | output | 1 | Sticky write-once violation flag |

## Verification
The assertions check the following on every cycle:
- the one-cycle read latency and the absence of spurious valid pulses;
- the 0xFF result of a data-out read whose enables are incomplete;
- that a locked program attempt both raises the error and leaves the word as it was;
- that a successful program lands the data-in bit at the selected position;
- that the error flag persists until it is cleared.

Only the bench scenarios can show the following:
- the reset contents, including the serial and complement words;
- the address masking;
- the redundancy-select veto;
- that writes to data out and to unmapped indices leave no trace;
- that the status clear works, and that a reset in the middle of a run restores the array.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [5:0] {
    REG_ADDR   = 6'd0,
    REG_BITSEL = 6'd1,
    REG_DIN    = 6'd2,
    REG_DOUT   = 6'd3,
    REG_CE     = 6'd4,
    REG_STROBE = 6'd5,
    REG_TRIM   = 6'd6,
    REG_PGM    = 6'd7,
    REG_RSEL   = 6'd8,
    REG_CLK    = 6'd9,
    REG_TMODE  = 6'd10,
    REG_TREP   = 6'd11,
    REG_TCTRL  = 6'd12,
    REG_PCTRL  = 6'd13,
    REG_STATUS = 6'd14
  } reg_idx_e;

  localparam int          NUM_REGS  = 15;
  localparam int          STORE_N   = 16;
  localparam logic [31:0] DOUT_IDLE = 32'h0000_00FF;

  function automatic bit is_plain(int i);
    return (i == 1) || (i == 2) || (i == 4) || (i == 5) || (i == 6) ||
           (i >= 8 && i <= 13);
  endfunction
endpackage

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [5:0]        idx_i,
  input  logic [31:0]       wdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [4:0]        bitsel_o,
  output logic              din_o,
  output logic              gate_o,
  output logic              pgm_o,
  output logic              clr_err_o,
  output logic [31:0]       rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              pgm_q;
  logic [31:0]       store_q [STORE_N];

  for (genvar i = 0; i < STORE_N; i++) begin : g_store
    if (is_plain(i)) begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        store_q[i] <= '0;
        else if (wr_i && idx_i == 6'(i))    store_q[i] <= wdata_i;
      end
    end else begin : g_none
      assign store_q[i] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      pgm_q  <= 1'b0;
    end else if (wr_i) begin
      if (idx_i == REG_ADDR) addr_q <= wdata_i[ADDR_W-1:0];
      if (idx_i == REG_PGM)  pgm_q  <= wdata_i[0];
    end
  end

  assign addr_o    = addr_q;
  assign bitsel_o  = store_q[REG_BITSEL][4:0];
  assign din_o     = store_q[REG_DIN][0];
  assign gate_o    = store_q[REG_CE][0] & store_q[REG_STROBE][0] & store_q[REG_TRIM][0];
  // redundancy select must be clear for a program to start
  assign pgm_o     = wr_i && idx_i == REG_PGM && wdata_i[0] && store_q[REG_RSEL] == '0;
  assign clr_err_o = wr_i && idx_i == REG_STATUS && wdata_i[0];

  always_comb begin
    case (idx_i)
      REG_ADDR: rdata_o = 32'(addr_q);
      REG_PGM:  rdata_o = {31'b0, pgm_q};
      default:  rdata_o = (idx_i < 6'(NUM_REGS)) ? store_q[idx_i[3:0]] : '0;
    endcase
  end
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int          ADDR_W     = 10,
  parameter logic [31:0] SERIAL     = 32'h0,
  parameter int          SERIAL_IDX = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [4:0]        bit_i,
  input  logic              din_i,
  input  logic              clr_err_i,
  output logic [31:0]       word_o,
  output logic              err_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [31:0] fuse_q [DEPTH];
  logic [31:0] wmap_q [DEPTH];
  logic        err_q;
  logic        lock_hit;

  assign lock_hit = wmap_q[addr_i][bit_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        fuse_q[i] <= (i == SERIAL_IDX)     ? SERIAL  :
                     (i == SERIAL_IDX + 1) ? ~SERIAL : '1;
        wmap_q[i] <= '0;
      end
    end else if (pgm_i && !lock_hit) begin
      fuse_q[addr_i][bit_i] <= din_i;
      wmap_q[addr_i][bit_i] <= 1'b1;
    end
  end

  // new violation beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 err_q <= 1'b0;
    else if (pgm_i && lock_hit)  err_q <= 1'b1;
    else if (clr_err_i)          err_q <= 1'b0;
  end

  assign word_o = fuse_q[addr_i];
  assign err_o  = err_q;

  AST_LOCK_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_i && lock_hit |=> err_o); // R7
  AST_LOCK_KEEPS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_i && lock_hit |=> word_o == $past(word_o)); // R7
  AST_PGM_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_i && !lock_hit |=> word_o[$past(bit_i)] == $past(din_i)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_err_i |=> err_o); // R8
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int          ADDR_W     = 10,
  parameter logic [31:0] SERIAL     = 32'hA5C3_1E07,
  parameter int          SERIAL_IDX = 252
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  output logic        err_o
);
  logic [5:0]        idx;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] fuse_addr;
  logic [4:0]        bitsel;
  logic              din, gate, pgm, clr_err, err;
  logic [31:0]       reg_rdata, word, rd_mux, rdata_q;
  logic              rvalid_q;

  assign idx   = addr_i[7:2];
  assign wr_en = req_i & we_i;
  assign rd_en = req_i & ~we_i;

  otp_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni,
    .wr_i(wr_en), .idx_i(idx), .wdata_i,
    .addr_o(fuse_addr), .bitsel_o(bitsel), .din_o(din), .gate_o(gate),
    .pgm_o(pgm), .clr_err_o(clr_err), .rdata_o(reg_rdata)
  );

  otp_fuse_array #(.ADDR_W(ADDR_W), .SERIAL(SERIAL), .SERIAL_IDX(SERIAL_IDX)) i_array (
    .clk_i, .rst_ni,
    .pgm_i(pgm), .addr_i(fuse_addr), .bit_i(bitsel), .din_i(din),
    .clr_err_i(clr_err), .word_o(word), .err_o(err)
  );

  always_comb begin
    case (idx)
      REG_DOUT:   rd_mux = gate ? word : DOUT_IDLE;
      REG_STATUS: rd_mux = {31'b0, err};
      default:    rd_mux = reg_rdata;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err;

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rvalid_o); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> !rvalid_o); // R1
  AST_DOUT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en && idx == REG_DOUT && !gate |=> rdata_o == DOUT_IDLE); // R3
endmodule

// File: tb/test_otp_fuse_ctrl.sv
module test_otp_fuse_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW    = 10;
  localparam int          DEPTH = 1 << AW;
  localparam logic [31:0] SER   = 32'hA5C3_1E07;
  localparam int          SIDX  = 252;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_o;
  logic rvalid_o, err_o;

  otp_fuse_ctrl #(.ADDR_W(AW), .SERIAL(SER), .SERIAL_IDX(SIDX)) i_otp_fuse_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o, .rvalid_o, .err_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_reg [16];
  logic [31:0] m_fuse [DEPTH];
  logic [31:0] m_wmap [DEPTH];
  bit          m_err;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic model_reset();
    foreach (m_reg[i]) m_reg[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      m_fuse[i] = (i == SIDX) ? SER : (i == SIDX + 1) ? ~SER : 32'hFFFF_FFFF;
      m_wmap[i] = '0;
    end
    m_err = 0;
    exp_q.delete(); tag_q.delete();
  endtask

  function automatic logic [31:0] model_rd(int idx);
    bit g = m_reg[4][0] & m_reg[5][0] & m_reg[6][0];
    if (idx == 3)  return g ? m_fuse[m_reg[0]] : 32'hFF;
    if (idx == 14) return {31'b0, m_err};
    if (idx < 15)  return m_reg[idx];
    return 0;
  endfunction

  task automatic model_wr(int idx, logic [31:0] d);
    int a, b;
    if (idx == 0) m_reg[0] = d & (DEPTH - 1);
    else if (idx == 7) begin
      m_reg[7] = {31'b0, d[0]};
      if (d[0] && m_reg[8] == 0) begin
        a = int'(m_reg[0]); b = int'(m_reg[1][4:0]);
        if (m_wmap[a][b]) m_err = 1;
        else begin m_fuse[a][b] = m_reg[2][0]; m_wmap[a][b] = 1'b1; end
      end
    end else if (idx == 14) begin
      if (d[0]) m_err = 0;
    end else if (idx < 15 && idx != 3) m_reg[idx] = d;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; req = 0; we = 0;
    model_wr(int'(a[7:2]), d);
  endtask

  task automatic rd(logic [7:0] a, string tag);
    logic [31:0] e;
    @(negedge clk); req = 1; we = 0; addr = a;
    e = model_rd(int'(a[7:2]));
    @(posedge clk); #1; req = 0;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rvalid_o) begin
        if (exp_q.size() == 0) check("R1 unexpected rvalid", 32'(rvalid_o), 32'h0);
        else check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end else if (exp_q.size() != 0) check("R1 missing rvalid", 32'(rvalid_o), 32'h1);
      check("R8 err_o", 32'(err_o), 32'(m_err));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    #(CLK_PERIOD * 3);
    check("R9 reset rvalid", 32'(rvalid_o), 0);
    check("R9 reset err", 32'(err_o), 0);
    @(negedge clk); rst_n = 1;

    rd(8'h0C, "R3 dout gated all off");
    wr(8'h24, 32'h1357_9BDF); wr(8'h28, 32'hCAFE_0001); wr(8'h2C, 32'h0000_FFFF);
    wr(8'h30, 32'h8000_0000); wr(8'h34, 32'h1234_5678); wr(8'h08, 32'hFFFF_FFFE);
    wr(8'h20, 32'h0000_0002);
    rd(8'h24, "R1 clk reg"); rd(8'h28, "R1 tmode reg"); rd(8'h2C, "R1 trepair reg");
    rd(8'h30, "R1 tctrl reg"); rd(8'h34, "R1 pctrl reg"); rd(8'h08, "R1 din reg");
    rd(8'h21, "R1 rsel reg low bits ignored");
    wr(8'h20, 32'h0);

    wr(8'h00, 32'hFFFF_FC00 | SIDX);
    rd(8'h00, "R4 address masked");
    wr(8'h10, 32'h1); wr(8'h14, 32'h3);
    rd(8'h0C, "R3 dout gated trim off");
    wr(8'h18, 32'h1);
    rd(8'h0C, "R9 serial word");
    wr(8'h00, SIDX + 1);
    rd(8'h0C, "R9 complement word");
    wr(8'h00, 32'd5);
    rd(8'h0C, "R9 erased word");
    wr(8'h0C, 32'h0);
    rd(8'h0C, "R2 dout write ignored");

    wr(8'h3C, 32'hDEAD_BEEF); wr(8'hFC, 32'h1);
    rd(8'h3C, "R10 unmapped 0x3C"); rd(8'h80, "R10 unmapped 0x80");
    rd(8'h24, "R10 plain reg untouched");

    wr(8'h04, 32'd3); wr(8'h08, 32'h0); wr(8'h1C, 32'h1);
    rd(8'h0C, "R6 clear bit 3");
    wr(8'h1C, 32'h2);
    rd(8'h1C, "R5 pgm stores bit0 only");
    rd(8'h0C, "R5 no program on bit0=0");
    wr(8'h08, 32'h1); wr(8'h1C, 32'h1);
    rd(8'h0C, "R7 relocked bit unchanged");
    rd(8'h38, "R8 status set");
    wr(8'h38, 32'h0);
    rd(8'h38, "R8 status kept by write 0");
    wr(8'h38, 32'h1);
    rd(8'h38, "R8 status cleared");

    wr(8'h20, 32'h1); wr(8'h04, 32'd4); wr(8'h08, 32'h0); wr(8'h1C, 32'h1);
    rd(8'h0C, "R5 redundancy select blocks");
    wr(8'h20, 32'h0); wr(8'h1C, 32'h1);
    rd(8'h0C, "R6 clear bit 4");
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'd31); wr(8'h1C, 32'h1);
    rd(8'h0C, "R6 top word top bit");
    wr(8'h00, 32'd6); wr(8'h04, 32'd0); wr(8'h08, 32'h1); wr(8'h1C, 32'h1);
    wr(8'h08, 32'h0); wr(8'h1C, 32'h1);
    rd(8'h0C, "R7 written-one stays locked");
    rd(8'h38, "R7 error flagged");
    wr(8'h10, 32'h0);
    rd(8'h0C, "R3 dout gated ce off");

    @(negedge clk); rst_n = 0; model_reset();
    #(CLK_PERIOD * 2);
    check("R9 mid-run reset err", 32'(err_o), 0);
    @(negedge clk); rst_n = 1;
    wr(8'h10, 32'h1); wr(8'h14, 32'h1); wr(8'h18, 32'h1); wr(8'h00, 32'd5);
    rd(8'h0C, "R9 word restored by reset");
    wr(8'h04, 32'd3); wr(8'h1C, 32'h1);
    rd(8'h0C, "R9 map cleared by reset");
    rd(8'h38, "R9 no error after reprogram");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule